// File: doc/BRIEF.md
# Mixed-Mode Return-From-NMI Sequencer

This block performs the stack side of a return from a non-maskable interrupt on a processor with two address modes. In the 16-bit mode an address is an 8-bit base register placed above a 16-bit offset. In the 24-bit mode addresses are linear. On a start pulse the block samples the current mode, a variant code, the base register, the short (16-bit) and long (24-bit) stack pointers, the current program counter and both interrupt-enable flags. It then pops bytes through a synchronous byte-read port and produces the new program counter, the new mode, the updated stack pointers and the new value of interrupt-enable flag 1. A single-cycle done pulse marks the end.

The long variants first pop a mode byte from the long stack. That byte decides how wide the return address is and which stack each later byte comes from. When a long return made from 16-bit mode lands in 24-bit mode, the upper address byte comes from the long stack and the two low bytes come from the short stack. The short-suffix request is invalid in mixed-mode code and is refused. A mode byte outside the two legal codes is flagged as an error and changes neither the program counter nor the mode.

Top module: `nmi_ret_seq`

## Requirements
- R1: Variant code 00 (plain) with mode 0 pops 2 bytes, low byte first, from address {base, short pointer}. It gives pc = {base, popped 16 bits}, keeps mode at 0, adds 2 to the short pointer and leaves the long pointer unchanged.
- R2: Variant code 00 with mode 1 pops 3 bytes, low byte first, from the long pointer. It gives pc = the popped 24 bits, keeps mode at 1, adds 3 to the long pointer and leaves the short pointer unchanged.
- R3: Variant code 01 (long, entered from 16-bit mode) pops a mode byte from the long stack. When that byte is 03h, the next long-stack byte becomes pc[23:16] and the low 16 bits are then popped, low byte first, from {base, short pointer}. The new mode is 1, the long pointer moves by 2 and the short pointer moves by 2.
- R4: Variant code 01 with mode byte 02h pops 2 bytes from {base, short pointer}. It gives pc = {base, popped 16 bits} and mode 0, moves the long pointer by 1 and the short pointer by 2.
- R5: Variant code 10 (long, entered from 24-bit mode) takes every byte from the long stack. With mode byte 03h it pops 3 address bytes, giving mode 1 and a long pointer moved by 4. With 02h it pops 2 address bytes, giving pc = {base, popped 16 bits}, mode 0 and a long pointer moved by 3.
- R6: Every completed return that has no error sets flag 1 to the value flag 2 had at start.
- R7: Variant code 11 (short suffix) is refused. The block makes no reads, raises the error flag, returns pc, mode and flag 1 equal to their start values, leaves both pointers unchanged and still gives done.
- R8: In a long variant, a mode byte other than 02h or 03h raises the error flag and leaves pc, mode and flag 1 at their start values. The long pointer has moved by 1, the short pointer is unchanged, and done still follows.
- R9: The short pointer wraps from FFFFh to 0000h within 16 bits, and the base byte of the address does not change when it wraps.
- R10: Each pop is one read strobe whose data is taken the following cycle. The number of cycles from the start edge up to and including the done cycle is 1 + 2 x (bytes popped). Reads occur only while busy.
- R11: Busy is high from the cycle after start through the done cycle. Done lasts one cycle. A start pulse while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start pulse, taken when idle |
| variant_i | input | 2 | 00 plain, 01 long from 16-bit, 10 long from 24-bit, 11 short suffix |
| mode_i | input | 1 | Current mode, 1 = 24-bit |
| base_i | input | 8 | Base register |
| sps_i | input | 16 | Short stack pointer |
| spl_i | input | 24 | Long stack pointer |
| pc_i | input | 24 | Current program counter |
| ief1_i | input | 1 | Interrupt-enable flag 1 |
| ief2_i | input | 1 | Interrupt-enable flag 2 |
| rd_en_o | output | 1 | Byte read strobe |
| rd_addr_o | output | 24 | Byte read address |
| rd_data_i | input | 8 | Read data, valid one cycle after the strobe |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Refused variant or bad mode byte |
| pc_o | output | 24 | New program counter |
| mode_o | output | 1 | New mode |
| sps_o | output | 16 | Updated short stack pointer |
| spl_o | output | 24 | Updated long stack pointer |
| ief1_o | output | 1 | New interrupt-enable flag 1 |

## Verification
The bench targets the split return. Here a design that uses one stack for all three bytes, or that treats the upper byte as the low byte, returns a wrong address and moves the wrong pointer. It runs both mode-byte outcomes of each long variant, so that a width chosen from the old mode instead of the popped one shows up as an extra or missing pop, a stray base byte, or a wrong cycle count. It places a short pop across the FFFFh boundary to catch a carry into the base byte. It also checks the refused variant, the illegal mode byte and a start pulse given mid-sequence: a design that lets these through would read memory, change the program counter or mode, or restart.

// File: rtl/nmi_ret_pkg.sv
package nmi_ret_pkg;
  typedef enum logic [1:0] {
    VAR_PLAIN  = 2'd0,
    VAR_LONG_S = 2'd1,
    VAR_LONG_L = 2'd2,
    VAR_SFX    = 2'd3
  } ret_var_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_MRD,
    ST_MWT,
    ST_BRD,
    ST_BWT,
    ST_DONE
  } seq_st_e;
endpackage

// File: rtl/nmi_ret_route.sv
// Chooses the stack and the address lane for each pop of the return address.
module nmi_ret_route
  import nmi_ret_pkg::*;
#(
  parameter int NLANE = 3,
  parameter int SLANE = 2,
  parameter int LW    = 2
) (
  input  ret_var_e        var_i,
  input  logic            wide_i,
  input  logic [LW-1:0]   idx_i,
  output logic            use_long_o,
  output logic [LW-1:0]   lane_o,
  output logic [LW-1:0]   last_idx_o
);
  logic upper_first;

  always_comb begin
    upper_first = (var_i == VAR_LONG_S) && wide_i;
    case (var_i)
      VAR_PLAIN:  use_long_o = wide_i;
      VAR_LONG_L: use_long_o = 1'b1;
      default:    use_long_o = upper_first && (idx_i == '0);
    endcase
    if (upper_first) begin
      lane_o = (idx_i == '0) ? LW'(NLANE - 1) : idx_i - LW'(1);
    end else begin
      lane_o = idx_i;
    end
    last_idx_o = wide_i ? LW'(NLANE - 1) : LW'(SLANE - 1);
  end
endmodule

// File: rtl/nmi_ret_ptrs.sv
// Holds both stack pointers and the base; forms the read address.
module nmi_ret_ptrs #(
  parameter int OFS_W  = 16,
  parameter int BASE_W = 8,
  localparam int LONG_W = OFS_W + BASE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_i,
  input  logic [OFS_W-1:0]  sps_i,
  input  logic [LONG_W-1:0] spl_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic              pop_i,
  input  logic              use_long_i,
  output logic [LONG_W-1:0] addr_o,
  output logic [OFS_W-1:0]  sps_o,
  output logic [LONG_W-1:0] spl_o,
  output logic [BASE_W-1:0] base_o
);
  logic [OFS_W-1:0]  sps_q, sps_n;
  logic [LONG_W-1:0] spl_q, spl_n;
  logic [BASE_W-1:0] base_q, base_n;

  always_comb begin
    sps_n  = sps_q;
    spl_n  = spl_q;
    base_n = base_q;
    if (load_i) begin
      sps_n  = sps_i;
      spl_n  = spl_i;
      base_n = base_i;
    end else if (pop_i) begin
      if (use_long_i) spl_n = spl_q + LONG_W'(1);
      else            sps_n = sps_q + OFS_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sps_q  <= '0;
      spl_q  <= '0;
      base_q <= '0;
    end else begin
      sps_q  <= sps_n;
      spl_q  <= spl_n;
      base_q <= base_n;
    end
  end

  assign addr_o = use_long_i ? spl_q : {base_q, sps_q};
  assign sps_o  = sps_q;
  assign spl_o  = spl_q;
  assign base_o = base_q;
endmodule

// File: rtl/nmi_ret_pcasm.sv
// Collects popped bytes into their address lanes.
module nmi_ret_pcasm #(
  parameter int NLANE = 3,
  parameter int LW    = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr_i,
  input  logic               cap_i,
  input  logic [LW-1:0]      lane_i,
  input  logic [7:0]         data_i,
  output logic [8*NLANE-1:0] acc_nxt_o
);
  for (genvar g = 0; g < NLANE; g++) begin : g_lane
    logic [7:0] q, n;
    always_comb begin
      n = q;
      if (clr_i) n = '0;
      else if (cap_i && (lane_i == LW'(g))) n = data_i;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= n;
    end
    assign acc_nxt_o[8*g +: 8] = n;
  end
endmodule

// File: rtl/nmi_ret_seq.sv
// Top: sequencer for the mixed-mode return from NMI.
// rst_n is asserted asynchronously; its release is expected to be synchronous to clk.
module nmi_ret_seq
  import nmi_ret_pkg::*;
#(
  parameter int          OFS_W      = 16,
  parameter int          BASE_W     = 8,
  parameter logic [7:0]  CODE_WIDE  = 8'h03,
  parameter logic [7:0]  CODE_NARROW = 8'h02,
  localparam int LONG_W = OFS_W + BASE_W,
  localparam int NLANE  = LONG_W / 8,
  localparam int SLANE  = OFS_W / 8,
  localparam int LW     = $clog2(NLANE)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [1:0]        variant_i,
  input  logic              mode_i,
  input  logic [BASE_W-1:0] base_i,
  input  logic [OFS_W-1:0]  sps_i,
  input  logic [LONG_W-1:0] spl_i,
  input  logic [LONG_W-1:0] pc_i,
  input  logic              ief1_i,
  input  logic              ief2_i,
  output logic              rd_en_o,
  output logic [LONG_W-1:0] rd_addr_o,
  input  logic [7:0]        rd_data_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              err_o,
  output logic [LONG_W-1:0] pc_o,
  output logic              mode_o,
  output logic [OFS_W-1:0]  sps_o,
  output logic [LONG_W-1:0] spl_o,
  output logic              ief1_o
);
  seq_st_e            st_q, st_n;
  ret_var_e           var_q, var_n;
  logic [LW-1:0]      idx_q, idx_n;
  logic               wide_q, wide_n;
  logic               ief2_q, ief2_n;
  logic [LONG_W-1:0]  pc_q, pc_n;
  logic               mode_q, mode_n;
  logic               ief1_q, ief1_n;
  logic               err_q, err_n;

  logic               load, pop, cap, rd_en;
  logic               route_long, use_long;
  logic [LW-1:0]      lane, last_idx;
  logic [BASE_W-1:0]  base_q;
  logic [8*NLANE-1:0] acc_nxt;

  nmi_ret_route #(.NLANE(NLANE), .SLANE(SLANE), .LW(LW)) route_i (
    .var_i(var_q), .wide_i(wide_q), .idx_i(idx_q),
    .use_long_o(route_long), .lane_o(lane), .last_idx_o(last_idx)
  );

  assign use_long = (st_q == ST_MRD) || route_long;

  nmi_ret_ptrs #(.OFS_W(OFS_W), .BASE_W(BASE_W)) ptrs_i (
    .clk(clk), .rst_n(rst_n), .load_i(load),
    .sps_i(sps_i), .spl_i(spl_i), .base_i(base_i),
    .pop_i(pop), .use_long_i(use_long),
    .addr_o(rd_addr_o), .sps_o(sps_o), .spl_o(spl_o), .base_o(base_q)
  );

  nmi_ret_pcasm #(.NLANE(NLANE), .LW(LW)) pcasm_i (
    .clk(clk), .rst_n(rst_n), .clr_i(load), .cap_i(cap),
    .lane_i(lane), .data_i(rd_data_i), .acc_nxt_o(acc_nxt)
  );

  always_comb begin
    st_n   = st_q;
    var_n  = var_q;
    idx_n  = idx_q;
    wide_n = wide_q;
    ief2_n = ief2_q;
    pc_n   = pc_q;
    mode_n = mode_q;
    ief1_n = ief1_q;
    err_n  = err_q;
    load   = 1'b0;
    pop    = 1'b0;
    cap    = 1'b0;
    rd_en  = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          load   = 1'b1;
          var_n  = ret_var_e'(variant_i);
          idx_n  = '0;
          wide_n = mode_i;
          ief2_n = ief2_i;
          pc_n   = pc_i;
          mode_n = mode_i;
          ief1_n = ief1_i;
          err_n  = 1'b0;
          case (ret_var_e'(variant_i))
            VAR_SFX: begin
              err_n = 1'b1;
              st_n  = ST_DONE;
            end
            VAR_PLAIN: st_n = ST_BRD;
            default:   st_n = ST_MRD;
          endcase
        end
      end
      ST_MRD: begin
        rd_en = 1'b1;
        pop   = 1'b1;
        st_n  = ST_MWT;
      end
      ST_MWT: begin
        if (rd_data_i == CODE_WIDE) begin
          wide_n = 1'b1;
          st_n   = ST_BRD;
        end else if (rd_data_i == CODE_NARROW) begin
          wide_n = 1'b0;
          st_n   = ST_BRD;
        end else begin
          err_n = 1'b1;
          st_n  = ST_DONE;
        end
      end
      ST_BRD: begin
        rd_en = 1'b1;
        pop   = 1'b1;
        st_n  = ST_BWT;
      end
      ST_BWT: begin
        cap = 1'b1;
        if (idx_q == last_idx) begin
          pc_n   = wide_q ? acc_nxt[LONG_W-1:0] : {base_q, acc_nxt[OFS_W-1:0]};
          mode_n = wide_q;
          ief1_n = ief2_q;
          st_n   = ST_DONE;
        end else begin
          idx_n = idx_q + LW'(1);
          st_n  = ST_BRD;
        end
      end
      ST_DONE: st_n = ST_IDLE;
      default: st_n = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      var_q  <= VAR_PLAIN;
      idx_q  <= '0;
      wide_q <= 1'b0;
      ief2_q <= 1'b0;
      pc_q   <= '0;
      mode_q <= 1'b0;
      ief1_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_n;
      var_q  <= var_n;
      idx_q  <= idx_n;
      wide_q <= wide_n;
      ief2_q <= ief2_n;
      pc_q   <= pc_n;
      mode_q <= mode_n;
      ief1_q <= ief1_n;
      err_q  <= err_n;
    end
  end

  assign rd_en_o = rd_en;
  assign busy_o  = (st_q != ST_IDLE);
  assign done_o  = (st_q == ST_DONE);
  assign err_o   = err_q;
  assign pc_o    = pc_q;
  assign mode_o  = mode_q;
  assign ief1_o  = ief1_q;
endmodule

// File: rtl/nmi_ret_chk.sv
module nmi_ret_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start_i,
  input logic [1:0] variant_i,
  input logic       mode_i,
  input logic       ief2_i,
  input logic       rd_en_o,
  input logic       busy_o,
  input logic       done_o,
  input logic       err_o,
  input logic       mode_o,
  input logic       ief1_o
);
  logic [1:0] cap_var;
  logic       cap_mode, cap_ief2;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_var  <= 2'd0;
      cap_mode <= 1'b0;
      cap_ief2 <= 1'b0;
    end else if (start_i && !busy_o) begin
      cap_var  <= variant_i;
      cap_mode <= mode_i;
      cap_ief2 <= ief2_i;
    end
  end

  AST_RD_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n) rd_en_o |-> busy_o); // R10
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n) done_o |=> !done_o); // R11
  AST_DONE_IN_BUSY: assert property (@(posedge clk) disable iff (!rst_n) done_o |-> busy_o); // R11
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && !done_o) |=> busy_o); // R11
  AST_REJECT_NO_READ: assert property (@(posedge clk) disable iff (!rst_n) (busy_o && cap_var == 2'd3) |-> !rd_en_o); // R7
  AST_REJECT_ERR: assert property (@(posedge clk) disable iff (!rst_n) (done_o && cap_var == 2'd3) |-> err_o); // R7
  AST_IEF_COPY: assert property (@(posedge clk) disable iff (!rst_n) (done_o && !err_o) |-> (ief1_o == cap_ief2)); // R6
  AST_PLAIN_KEEPS_MODE: assert property (@(posedge clk) disable iff (!rst_n) (done_o && cap_var == 2'd0) |-> (mode_o == cap_mode)); // R1
endmodule

bind nmi_ret_seq nmi_ret_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .variant_i(variant_i),
  .mode_i(mode_i), .ief2_i(ief2_i), .rd_en_o(rd_en_o), .busy_o(busy_o),
  .done_o(done_o), .err_o(err_o), .mode_o(mode_o), .ief1_o(ief1_o)
);

// File: tb/nmi_ret_seq_tb_top.sv
`timescale 1ns/1ps
module nmi_ret_seq_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [1:0]  variant = 2'd0;
  logic        mode = 1'b0;
  logic [7:0]  base = 8'h00;
  logic [15:0] sps = 16'h0000;
  logic [23:0] spl = 24'h000000;
  logic [23:0] pc_in = 24'h000000;
  logic        ief1 = 1'b0;
  logic        ief2 = 1'b0;
  logic        rd_en;
  logic [23:0] rd_addr;
  logic [7:0]  rd_data;
  logic        busy, done, err, mode_out, ief1_out;
  logic [23:0] pc_out, spl_out;
  logic [15:0] sps_out;

  logic [7:0] mem [0:4095];
  int n_chk = 0;
  int n_bad = 0;
  int rd_total = 0;
  int cycles, reads;

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rd_en) begin
      rd_data  <= mem[rd_addr[11:0]];
      rd_total <= rd_total + 1;
    end
  end

  nmi_ret_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start), .variant_i(variant),
    .mode_i(mode), .base_i(base), .sps_i(sps), .spl_i(spl), .pc_i(pc_in),
    .ief1_i(ief1), .ief2_i(ief2), .rd_en_o(rd_en), .rd_addr_o(rd_addr),
    .rd_data_i(rd_data), .busy_o(busy), .done_o(done), .err_o(err),
    .pc_o(pc_out), .mode_o(mode_out), .sps_o(sps_out), .spl_o(spl_out),
    .ief1_o(ief1_out)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic run(input logic [1:0] v, input logic m, input logic [7:0] b,
                     input logic [15:0] s, input logic [23:0] l, input logic [23:0] p,
                     input logic i1, input logic i2, input bit inject);
    int snap;
    @(negedge clk);
    variant = v; mode = m; base = b; sps = s; spl = l; pc_in = p;
    ief1 = i1; ief2 = i2; start = 1'b1;
    snap = rd_total;
    @(negedge clk);
    start = 1'b0;
    cycles = 1;
    while (!done && cycles < 50) begin
      chk("R11 busy during sequence", busy, 1'b1);
      if (inject && cycles == 2) begin
        start = 1'b1; variant = 2'd3; mode = ~m;
      end
      @(negedge clk);
      start = 1'b0;
      cycles++;
    end
    if (!done) chk("watchdog done R11", 0, 1);
    reads = rd_total - snap;
  endtask

  task automatic after_done(input string tag);
    @(negedge clk);
    chk({tag, " done pulse ends R11"}, done, 1'b0);
    chk({tag, " busy drops R11"}, busy, 1'b0);
  endtask

  task automatic t_plain16;
    mem[12'h340] = 8'hCD; mem[12'h341] = 8'hAB;
    run(2'd0, 1'b0, 8'h12, 16'h0340, 24'h000800, 24'h0F0F0F, 1'b0, 1'b1, 0);
    chk("R1 pc", pc_out, 24'h12ABCD);
    chk("R1 mode", mode_out, 1'b0);
    chk("R1 sps", sps_out, 16'h0342);
    chk("R1 spl", spl_out, 24'h000800);
    chk("R6 ief1", ief1_out, 1'b1);
    chk("R1 err", err, 1'b0);
    chk("R10 cycles", cycles, 5);
    chk("R10 reads", reads, 2);
    after_done("R1");
  endtask

  task automatic t_plain24(input bit inject);
    mem[12'h800] = 8'h11; mem[12'h801] = 8'h22; mem[12'h802] = 8'h33;
    run(2'd0, 1'b1, 8'h12, 16'h0340, 24'h000800, 24'h0F0F0F, 1'b1, 1'b0, inject);
    chk("R2 pc", pc_out, 24'h332211);
    chk("R2 mode", mode_out, 1'b1);
    chk("R2 spl", spl_out, 24'h000803);
    chk("R2 sps", sps_out, 16'h0340);
    chk("R6 ief1", ief1_out, 1'b0);
    chk("R2 err", err, 1'b0);
    chk("R10 cycles", cycles, 7);
    chk("R10 reads", reads, 3);
    after_done(inject ? "R11" : "R2");
  endtask

  task automatic t_long16_wide;
    mem[12'h900] = 8'h03; mem[12'h901] = 8'h7E;
    mem[12'hA00] = 8'h34; mem[12'hA01] = 8'h12;
    run(2'd1, 1'b0, 8'h05, 16'h0A00, 24'h000900, 24'h000000, 1'b0, 1'b1, 0);
    chk("R3 pc", pc_out, 24'h7E1234);
    chk("R3 mode", mode_out, 1'b1);
    chk("R3 spl", spl_out, 24'h000902);
    chk("R3 sps", sps_out, 16'h0A02);
    chk("R6 ief1", ief1_out, 1'b1);
    chk("R10 cycles", cycles, 9);
    after_done("R3");
  endtask

  task automatic t_long16_narrow;
    mem[12'hB00] = 8'h02;
    mem[12'hC00] = 8'hEF; mem[12'hC01] = 8'hBE;
    run(2'd1, 1'b0, 8'h44, 16'h0C00, 24'h000B00, 24'h000000, 1'b1, 1'b0, 0);
    chk("R4 pc", pc_out, 24'h44BEEF);
    chk("R4 mode", mode_out, 1'b0);
    chk("R4 spl", spl_out, 24'h000B01);
    chk("R4 sps", sps_out, 16'h0C02);
    chk("R6 ief1", ief1_out, 1'b0);
    chk("R10 cycles", cycles, 7);
    chk("R10 reads", reads, 3);
  endtask

  task automatic t_long24;
    mem[12'hD00] = 8'h03; mem[12'hD01] = 8'h01; mem[12'hD02] = 8'h02; mem[12'hD03] = 8'h03;
    run(2'd2, 1'b1, 8'h66, 16'h0100, 24'h000D00, 24'h000000, 1'b0, 1'b1, 0);
    chk("R5 wide pc", pc_out, 24'h030201);
    chk("R5 wide mode", mode_out, 1'b1);
    chk("R5 wide spl", spl_out, 24'h000D04);
    chk("R5 wide sps", sps_out, 16'h0100);
    chk("R10 reads", reads, 4);
    mem[12'hE00] = 8'h02; mem[12'hE01] = 8'hAA; mem[12'hE02] = 8'h55;
    run(2'd2, 1'b1, 8'h66, 16'h0100, 24'h000E00, 24'h000000, 1'b0, 1'b1, 0);
    chk("R5 narrow pc", pc_out, 24'h6655AA);
    chk("R5 narrow mode", mode_out, 1'b0);
    chk("R5 narrow spl", spl_out, 24'h000E03);
    chk("R5 narrow sps", sps_out, 16'h0100);
  endtask

  task automatic t_reject;
    run(2'd3, 1'b1, 8'h21, 16'h0400, 24'h000500, 24'h135790, 1'b0, 1'b1, 0);
    chk("R7 err", err, 1'b1);
    chk("R7 pc", pc_out, 24'h135790);
    chk("R7 mode", mode_out, 1'b1);
    chk("R7 ief1", ief1_out, 1'b0);
    chk("R7 sps", sps_out, 16'h0400);
    chk("R7 spl", spl_out, 24'h000500);
    chk("R7 reads", reads, 0);
    chk("R7 cycles", cycles, 1);
    after_done("R7");
  endtask

  task automatic t_badmode;
    mem[12'hF00] = 8'h07;
    run(2'd1, 1'b0, 8'h21, 16'h0400, 24'h000F00, 24'h2468AC, 1'b0, 1'b1, 0);
    chk("R8 err", err, 1'b1);
    chk("R8 pc", pc_out, 24'h2468AC);
    chk("R8 mode", mode_out, 1'b0);
    chk("R8 ief1", ief1_out, 1'b0);
    chk("R8 spl", spl_out, 24'h000F01);
    chk("R8 sps", sps_out, 16'h0400);
    chk("R8 cycles", cycles, 3);
    chk("R8 reads", reads, 1);
  endtask

  task automatic t_wrap;
    mem[12'hFFF] = 8'h78; mem[12'h000] = 8'h56;
    run(2'd0, 1'b0, 8'h21, 16'hFFFF, 24'h000700, 24'h000000, 1'b0, 1'b1, 0);
    chk("R9 pc", pc_out, 24'h215678);
    chk("R9 sps", sps_out, 16'h0001);
    chk("R9 spl", spl_out, 24'h000700);
  endtask

  initial begin
    #200000;
    n_chk++; n_bad++;
    $display("FAIL watchdog expired R11 actual=hung expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("reset busy R11", busy, 1'b0);
    chk("reset done R11", done, 1'b0);
    chk("reset rd_en R10", rd_en, 1'b0);
    rst_n = 1'b1;
    t_plain16();
    t_plain24(0);
    t_long16_wide();
    t_long16_narrow();
    t_long24();
    t_reject();
    t_badmode();
    t_wrap();
    t_plain24(1);
    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule